// File: doc/BRIEF.md
# Frame-Timed Soft Reset Sequencer

This block converts a software run/reset control bit into the internal reset of a DAC digital datapath. It does not change state the moment the bit changes. Entry into reset and exit from it are both timed in audio sample frames. A frame is one full period of the word clock, and each frame is marked by a rising word-clock edge after that edge has been synchronized into the system clock domain. The entry delay and the exit delay differ. Clearing the control bit only holds the datapath in reset; the block keeps no configuration that could be lost.

While the internal reset is active, the sample stream leaving the block is forced to zero (mid-scale), whatever samples arrive. A zero-detect flag follows its own timing. It rises as soon as the control bit is sampled low, which is before the reset takes effect. It stays high through the reset and falls a fixed number of frames after the reset is released. If the control bit is cleared while a separate power-off request is still active, a sticky ordering-error flag is set. The correct order is to clear power-off first.

Top module: `frame_reset_seq`

## Requirements
- R1: While hardware reset (rst_n low) is applied, and right after it, dp_rst is 1, zero_flag is 1, order_err is 0 and sample_out is 0.
- R2: If the block is running (dp_rst 0, zero_flag 0) and run_ctl is first sampled 0 at a clock edge, zero_flag is 1 after that edge and dp_rst is still 0.
- R3: After run_ctl falls, dp_rst rises on the 4th counted frame edge. The delay is therefore between 3 and 4 word-clock periods.
- R4: After run_ctl returns to 1 while in reset, dp_rst falls on the 3rd counted frame edge. The delay is therefore between 2 and 3 word-clock periods.
- R5: zero_flag falls exactly 2 word-clock periods after dp_rst falls, as long as run_ctl stays 1.
- R6: sample_out is registered. After each clock edge it holds 0 if dp_rst was 1 before that edge, and otherwise the sample_in value present at that edge.
- R7: Only rising edges of lrck count as frames. An edge first sampled high at clock edge k advances the sequencer at edge k+2, after two synchronizer flops. While lrck does not toggle, the pending delay holds its progress.
- R8: If run_ctl changes back before a pending entry or exit completes, the pending transition is cancelled: dp_rst keeps its current value, and a later change starts a fresh count.
- R9: order_err becomes 1 after any clock edge where pwr_off_req is 1 and run_ctl is sampled 0 after being sampled 1 at the previous edge. order_err then stays 1 until hardware reset. pwr_off_req rising while run_ctl is already 0 does not set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| lrck | input | 1 | Word (frame) clock, asynchronous to clk |
| run_ctl | input | 1 | Control bit: 1 = run, 0 = hold datapath in reset |
| pwr_off_req | input | 1 | Separate power-off request, used for the ordering check |
| sample_in | input | DATA_W | Incoming sample data |
| dp_rst | output | 1 | Internal datapath reset, active high |
| sample_out | output | DATA_W | Gated sample data, zero while in reset |
| zero_flag | output | 1 | Zero-detect flag |
| order_err | output | 1 | Sticky reset/power-off ordering error |

## Verification
The assertions assume that run_ctl and pwr_off_req are synchronous to clk. They also assume that lrck changes slowly compared with clk, so each frame edge is seen as one clean tick. The stimulus meets these assumptions by changing every input on the falling edge of clk. It toggles lrck only every few system cycles and stalls it now and then to exercise holding. Random run_ctl hold times range from much shorter than a frame to several frames, which covers both cancelled and completed transitions.

// File: rtl/srs_pkg.sv
package srs_pkg;
    typedef enum logic [2:0] {
        ST_RUN,
        ST_ZHOLD,
        ST_ENTER,
        ST_RESET,
        ST_LEAVE
    } seq_state_e;
endpackage

// File: rtl/srs_frame_edge.sv
module srs_frame_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lrck,
    output logic frame_tick
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_reg_t;

    edge_reg_t edge_d, edge_q;

    always_comb begin
        edge_d      = edge_q;
        edge_d.sync = {edge_q.sync[SYNC_STAGES-2:0], lrck};
        edge_d.prev = edge_q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_q <= '0;
        else        edge_q <= edge_d;
    end

    assign frame_tick = edge_q.sync[SYNC_STAGES-1] & ~edge_q.prev;

    p_tick_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> !frame_tick);
endmodule

// File: rtl/srs_seq.sv
module srs_seq
    import srs_pkg::*;
#(
    parameter int ENTER_FRAMES = 3,
    parameter int LEAVE_FRAMES = 2,
    parameter int ZHOLD_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_tick,
    input  logic run_ctl,
    input  logic pwr_off_req,
    output logic dp_rst,
    output logic zero_flag,
    output logic order_err
);
    localparam int MAXF = (ENTER_FRAMES > LEAVE_FRAMES) ?
        ((ENTER_FRAMES > ZHOLD_FRAMES) ? ENTER_FRAMES : ZHOLD_FRAMES) :
        ((LEAVE_FRAMES > ZHOLD_FRAMES) ? LEAVE_FRAMES : ZHOLD_FRAMES);
    localparam int CW = $clog2(MAXF + 1);
    localparam logic [CW-1:0] ENTER_LAST = CW'(ENTER_FRAMES);
    localparam logic [CW-1:0] LEAVE_LAST = CW'(LEAVE_FRAMES);
    localparam logic [CW-1:0] ZHOLD_LAST = CW'(ZHOLD_FRAMES - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic          ctl_prev;
        logic          err;
    } seq_reg_t;

    seq_reg_t seq_d, seq_q;

    always_comb begin
        seq_d          = seq_q;
        seq_d.ctl_prev = run_ctl;
        if (seq_q.ctl_prev && !run_ctl && pwr_off_req) seq_d.err = 1'b1;
        case (seq_q.st)
            ST_RUN: begin
                if (!run_ctl) begin
                    seq_d.st  = ST_ENTER;
                    seq_d.cnt = '0;
                end
            end
            ST_ZHOLD: begin
                if (!run_ctl) begin
                    seq_d.st  = ST_ENTER;
                    seq_d.cnt = '0;
                end else if (frame_tick) begin
                    if (seq_q.cnt == ZHOLD_LAST) begin
                        seq_d.st  = ST_RUN;
                        seq_d.cnt = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            ST_ENTER: begin
                if (run_ctl) begin
                    seq_d.st  = ST_RUN;
                    seq_d.cnt = '0;
                end else if (frame_tick) begin
                    if (seq_q.cnt == ENTER_LAST) begin
                        seq_d.st  = ST_RESET;
                        seq_d.cnt = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            ST_RESET: begin
                if (run_ctl) begin
                    seq_d.st  = ST_LEAVE;
                    seq_d.cnt = '0;
                end
            end
            ST_LEAVE: begin
                if (!run_ctl) begin
                    seq_d.st  = ST_RESET;
                    seq_d.cnt = '0;
                end else if (frame_tick) begin
                    if (seq_q.cnt == LEAVE_LAST) begin
                        seq_d.st  = ST_ZHOLD;
                        seq_d.cnt = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                seq_d.st  = ST_RESET;
                seq_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st       <= ST_RESET;
            seq_q.cnt      <= '0;
            seq_q.ctl_prev <= 1'b0;
            seq_q.err      <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign dp_rst    = (seq_q.st == ST_RESET) || (seq_q.st == ST_LEAVE);
    assign zero_flag = (seq_q.st != ST_RUN);
    assign order_err = seq_q.err;

    p_flag_covers_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dp_rst |-> zero_flag);
    p_flag_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_RUN && !run_ctl) |=> (zero_flag && !dp_rst));
    p_hold_no_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_ENTER && !run_ctl && !frame_tick) |=>
            ($stable(seq_q.cnt) && seq_q.st == ST_ENTER));
    p_cancel_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_LEAVE && !run_ctl) |=> (dp_rst && seq_q.st == ST_RESET));
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        order_err |=> order_err);
endmodule

// File: rtl/srs_gate.sv
module srs_gate #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dp_rst,
    input  logic [DATA_W-1:0] sample_in,
    output logic [DATA_W-1:0] sample_out
);
    logic [DATA_W-1:0] smp_d, smp_q;

    always_comb begin
        smp_d = dp_rst ? '0 : sample_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    assign sample_out = smp_q;
endmodule

// File: rtl/frame_reset_seq.sv
module frame_reset_seq #(
    parameter int DATA_W       = 24,
    parameter int SYNC_STAGES  = 2,
    parameter int ENTER_FRAMES = 3,
    parameter int LEAVE_FRAMES = 2,
    parameter int ZHOLD_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lrck,
    input  logic              run_ctl,
    input  logic              pwr_off_req,
    input  logic [DATA_W-1:0] sample_in,
    output logic              dp_rst,
    output logic [DATA_W-1:0] sample_out,
    output logic              zero_flag,
    output logic              order_err
);
    logic frame_tick;

    srs_frame_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .lrck       (lrck),
        .frame_tick (frame_tick)
    );

    srs_seq #(
        .ENTER_FRAMES (ENTER_FRAMES),
        .LEAVE_FRAMES (LEAVE_FRAMES),
        .ZHOLD_FRAMES (ZHOLD_FRAMES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_tick  (frame_tick),
        .run_ctl     (run_ctl),
        .pwr_off_req (pwr_off_req),
        .dp_rst      (dp_rst),
        .zero_flag   (zero_flag),
        .order_err   (order_err)
    );

    srs_gate #(.DATA_W(DATA_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .dp_rst     (dp_rst),
        .sample_in  (sample_in),
        .sample_out (sample_out)
    );

    p_gate_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dp_rst) |-> (sample_out == '0));
    p_rise_on_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dp_rst) |-> $past(frame_tick));
    p_fall_on_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dp_rst) |-> $past(frame_tick));
endmodule

// File: tb/frame_reset_seq_test.sv
module frame_reset_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 24;
    localparam int HALF       = 4;
    localparam int FR         = 2 * HALF;
    localparam int WD_CYCLES  = 190000;
    localparam int M_RUN = 0, M_ZHOLD = 1, M_ENTER = 2, M_RESET = 3, M_LEAVE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lrck = 1'b0;
    logic run_ctl = 1'b0;
    logic pwr_off_req = 1'b0;
    logic [DATA_W-1:0] sample_in = '0;
    logic dp_rst, zero_flag, order_err;
    logic [DATA_W-1:0] sample_out;

    int n_checks = 0;
    int n_errors = 0;
    bit lrck_en = 1'b1;
    int ph = 0;
    bit done = 1'b0;

    frame_reset_seq #(.DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .lrck(lrck), .run_ctl(run_ctl),
        .pwr_off_req(pwr_off_req), .sample_in(sample_in), .dp_rst(dp_rst),
        .sample_out(sample_out), .zero_flag(zero_flag), .order_err(order_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (lrck_en) begin
            if (ph == HALF - 1) begin lrck <= ~lrck; ph <= 0; end
            else ph <= ph + 1;
        end
        sample_in <= DATA_W'($urandom);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model built from R2-R9
    int m_st = M_RESET, m_cnt = 0;
    bit m_prev = 0, m_err = 0, l1 = 0, l2 = 0, l3 = 0;
    int m_out = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = M_RESET; m_cnt = 0; m_prev = 0; m_err = 0;
            l1 = 0; l2 = 0; l3 = 0; m_out = 0;
        end else begin
            bit t;
            t = l2 && !l3;
            m_out = (m_st == M_RESET || m_st == M_LEAVE) ? 0 : int'(sample_in);
            if (m_prev && !run_ctl && pwr_off_req) m_err = 1;
            if (m_st == M_RUN || m_st == M_ZHOLD) begin
                if (!run_ctl) begin m_st = M_ENTER; m_cnt = 0; end
                else if (m_st == M_ZHOLD && t) begin
                    m_cnt++;
                    if (m_cnt == 2) begin m_st = M_RUN; m_cnt = 0; end
                end
            end else if (m_st == M_ENTER) begin
                if (run_ctl) begin m_st = M_RUN; m_cnt = 0; end
                else if (t) begin
                    m_cnt++;
                    if (m_cnt == 4) begin m_st = M_RESET; m_cnt = 0; end
                end
            end else if (m_st == M_RESET) begin
                if (run_ctl) begin m_st = M_LEAVE; m_cnt = 0; end
            end else begin
                if (!run_ctl) begin m_st = M_RESET; m_cnt = 0; end
                else if (t) begin
                    m_cnt++;
                    if (m_cnt == 3) begin m_st = M_ZHOLD; m_cnt = 0; end
                end
            end
            m_prev = run_ctl;
            l3 = l2; l2 = l1; l1 = lrck;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit e_rst, e_zf;
            e_rst = (m_st == M_RESET || m_st == M_LEAVE);
            e_zf  = (m_st != M_RUN);
            chk(dp_rst == e_rst, "R3 R4 R7 R8 dp_rst", int'(dp_rst), int'(e_rst));
            chk(zero_flag == e_zf, "R2 R5 zero_flag", int'(zero_flag), int'(e_zf));
            chk(int'(sample_out) == m_out, "R6 sample_out", int'(sample_out), m_out);
            chk(order_err == m_err, "R9 order_err", int'(order_err), int'(m_err));
        end
    end

    task automatic wait_level(input bit which_rst, input bit lvl, input int lim,
                              input string req, output int cyc);
        cyc = 0;
        while (((which_rst ? dp_rst : zero_flag) != lvl) && cyc < lim) begin
            @(negedge clk); cyc++;
        end
        chk(cyc < lim, req, cyc, lim);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int cyc;
        void'($urandom(32'd2718));
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(dp_rst == 1, "R1 dp_rst", int'(dp_rst), 1);
        chk(zero_flag == 1, "R1 zero_flag", int'(zero_flag), 1);
        chk(order_err == 0, "R1 order_err", int'(order_err), 0);
        chk(sample_out == '0, "R1 sample_out", int'(sample_out), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R4 exit delay, then R5 zero-flag hold
        run_ctl = 1'b1;
        @(negedge clk);
        wait_level(1, 0, 10 * FR, "R4 exit", cyc);
        cyc++;
        chk(cyc >= 2 * FR && cyc <= 3 * FR, "R4 exit window", cyc, 3 * FR);
        wait_level(0, 0, 10 * FR, "R5 flag", cyc);
        chk(cyc == 2 * FR, "R5 flag delay", cyc, 2 * FR);

        // R2 and R3
        repeat ($urandom_range(1, 9)) @(negedge clk);
        run_ctl = 1'b0;
        @(negedge clk);
        chk(zero_flag == 1 && dp_rst == 0, "R2 flag early", int'({zero_flag, dp_rst}), 2);
        wait_level(1, 1, 10 * FR, "R3 entry", cyc);
        cyc++;
        chk(cyc >= 3 * FR && cyc <= 4 * FR, "R3 entry window", cyc, 4 * FR);

        // R8: cancelled exit keeps reset
        run_ctl = 1'b1;
        repeat (FR) @(negedge clk);
        run_ctl = 1'b0;
        cyc = 0;
        repeat (8 * FR) begin @(negedge clk); if (!dp_rst) cyc++; end
        chk(cyc == 0, "R8 cancel exit", cyc, 0);
        run_ctl = 1'b1;
        wait_level(0, 0, 20 * FR, "R8 run", cyc);
        run_ctl = 1'b0;
        repeat (FR) @(negedge clk);
        run_ctl = 1'b1;
        cyc = 0;
        repeat (8 * FR) begin @(negedge clk); if (dp_rst) cyc++; end
        chk(cyc == 0, "R8 cancel entry", cyc, 0);
        chk(zero_flag == 0, "R8 flag after cancel", int'(zero_flag), 0);

        // R7: stalled frame clock holds the entry count
        run_ctl = 1'b0;
        lrck_en = 1'b0;
        cyc = 0;
        repeat (30 * FR) begin @(negedge clk); if (dp_rst) cyc++; end
        chk(cyc == 0, "R7 stall holds", cyc, 0);
        lrck_en = 1'b1;
        wait_level(1, 1, 6 * FR, "R7 resume", cyc);

        // R9: no error when power-off rises with control already low
        pwr_off_req = 1'b1;
        repeat (4) @(negedge clk);
        chk(order_err == 0, "R9 no error", int'(order_err), 0);
        run_ctl = 1'b1;
        repeat (2) @(negedge clk);
        run_ctl = 1'b0;
        @(negedge clk);
        chk(order_err == 1, "R9 error set", int'(order_err), 1);
        pwr_off_req = 1'b0;
        run_ctl = 1'b1;
        repeat (6 * FR) @(negedge clk);
        chk(order_err == 1, "R9 sticky", int'(order_err), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(order_err == 0, "R1 R9 cleared by reset", int'(order_err), 0);
        rst_n = 1'b1;

        // Random phase checked against the model
        for (int i = 0; i < 1500; i++) begin
            run_ctl     = ($urandom_range(0, 1) == 1);
            pwr_off_req = ($urandom_range(0, 19) == 0);
            lrck_en     = ($urandom_range(0, 9) != 0);
            repeat ($urandom_range(1, 6 * FR)) @(negedge clk);
        end
        lrck_en = 1'b1;
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule